// File: doc/BRIEF.md
# DMA Request Admission Checker

This block sits between a host that submits DMA transfer descriptors and the queue that a downstream transfer engine drains. Each descriptor holds a source address, a destination address, a byte count, an operation code, an address-stepping code and a width-pairing code. The block judges every submission against a set of legality rules. Some rules look at one field. Others look at how two fields combine. The block answers each submission with a status code one clock after it is offered.

A descriptor that passes every rule is written into a pending queue of parameterised depth, 16 by default. A descriptor that fails any rule is never written. The queue presents its oldest entry to the engine in first-word fall-through fashion, and the engine removes that entry by raising `deq_ready`. A pending-count output shows the queue occupancy for debug.

The block refuses all submissions until it has seen an arm pulse after reset. When several rules fail at once, only the highest-priority failure is reported.

Top module: `dma_admit_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `resp_valid` is 0, `pend_count` is 0 and `q_valid` is 0. `q_valid` always equals (`pend_count` != 0).
- R2: A submission made before any `arm` pulse has been registered since reset returns status 1 (generic fail). This includes a submission in the same cycle as the first pulse. Such a submission is not queued.
- R3: The operation code `req_op` is 0 = copy then clear source, 1 = copy, 2 = copy with byte swap within each word, 3 = copy with reverse. Any code of 4 or more returns status 4 (bad operation).
- R4: The stepping code `req_step` is 0 = both addresses increment, 1 = source increments and destination is fixed, 2 = source is fixed and destination increments, 3 = both addresses fixed. Code 3 returns status 5 (bad stepping).
- R5: The width code `req_width` is decoded as follows. Codes 0 to 8 pair a 32-, 16- or 8-bit source with a 32-, 16- or 8-bit destination, source-major in that order. Codes 9 to 11 are an 8-, 16- or 32-bit source to a burst destination. Codes 12 to 14 are a burst source to an 8-, 16- or 32-bit destination. Code 15 is burst to burst. Status 2 (bad width) is returned in three cases: the code is 16 or more; the destination side is burst (codes 9 to 11 and 15) while the stepping code is 1; or the source side is burst (codes 12 to 15) while the stepping code is 2.
- R6: A byte count `req_len` (17 bits) of 0, or of more than 65536, returns status 3 (bad length). Counts of 1 and 65536 are accepted.
- R7: With operation code 2 or 3, a byte count that is not a multiple of 4 returns status 3 (bad length).
- R8: Checks are ranked in this order: not armed (1), then operation (4), then stepping (5), then width (2), then length (3), then queue full (6). Only the first failing check is reported.
- R9: A legal submission offered while `pend_count` equals the queue depth returns status 6 (queue full) and is not queued. This holds even if a pop happens in the same cycle.
- R10: A legal submission returns status 0 (success) and is appended to the queue. The queue delivers entries in submission order, with every field unchanged, on the `q_*` outputs.
- R11: `pend_count` changes in the cycle after the event: it rises by 1 after a push, falls by 1 after a pop of a non-empty queue, and stays unchanged after a simultaneous push and pop. A `deq_ready` on an empty queue has no effect.
- R12: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `resp_status` holds that submission's code in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Arm pulse; enables admission from the next cycle |
| req_valid | input | 1 | Submission strobe |
| req_src | input | AW | Source start address |
| req_dst | input | AW | Destination start address |
| req_len | input | LEN_W | Byte count |
| req_op | input | 3 | Operation code |
| req_step | input | 2 | Address-stepping code |
| req_width | input | 5 | Width-pairing code |
| resp_valid | output | 1 | Status strobe, one cycle after req_valid |
| resp_status | output | 3 | 0 ok, 1 fail, 2 width, 3 length, 4 op, 5 stepping, 6 full |
| deq_ready | input | 1 | Engine removes head entry |
| q_valid | output | 1 | Queue not empty |
| q_src | output | AW | Head entry source address |
| q_dst | output | AW | Head entry destination address |
| q_len | output | LEN_W | Head entry byte count |
| q_op | output | 3 | Head entry operation code |
| q_step | output | 2 | Head entry stepping code |
| q_width | output | 5 | Head entry width code |
| pend_count | output | CNT_W | Number of queued entries |

## Verification
The bench targets three kinds of cases.

Combined failures test the ranking. For example, a bad operation together with fixed-to-fixed stepping must report the operation error. A design with the checks in the wrong order would return the stepping code instead.

Cross-field cases test rules that depend on two fields at once. Burst width is paired with each fixed side. Swap and reverse operations are given lengths that are not multiples of 4. Lengths of exactly 65536 and 65537 probe the upper limit. A design that judged each field alone would accept the illegal pairings, and an off-by-one limit would flip one of the two length results.

Occupancy cases cover a full queue with a pop in the same cycle, a push together with a pop, and `deq_ready` on an empty queue. A design with a wrong full test would overflow and lose or duplicate entries, and that shows up as mismatched head fields during the drain.

// File: rtl/dma_adm_pkg.sv
package dma_adm_pkg;
  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_FAIL      = 3'd1,
    ST_BAD_WIDTH = 3'd2,
    ST_BAD_LEN   = 3'd3,
    ST_BAD_OP    = 3'd4,
    ST_BAD_STEP  = 3'd5,
    ST_FULL      = 3'd6
  } adm_status_e;

  localparam int OP_W    = 3;
  localparam int STEP_W  = 2;
  localparam int WIDTH_W = 5;

  localparam logic [OP_W-1:0]   OP_SWAP     = 3'd2;
  localparam logic [OP_W-1:0]   OP_REVERSE  = 3'd3;
  localparam logic [OP_W-1:0]   OP_LIMIT    = 3'd4;
  localparam logic [STEP_W-1:0] STEP_FIXDST = 2'd1;
  localparam logic [STEP_W-1:0] STEP_FIXSRC = 2'd2;
  localparam logic [STEP_W-1:0] STEP_FIXALL = 2'd3;
endpackage

// File: rtl/dma_adm_width_dec.sv
module dma_adm_width_dec
  import dma_adm_pkg::*;
(
  input  logic [WIDTH_W-1:0] code,
  output logic               code_ok,
  output logic               src_burst,
  output logic               dst_burst
);
  always_comb begin
    code_ok   = (code < 5'd16);
    src_burst = (code >= 5'd12) && (code <= 5'd15);
    dst_burst = ((code >= 5'd9) && (code <= 5'd11)) || (code == 5'd15);
  end
endmodule

// File: rtl/dma_adm_rules.sv
module dma_adm_rules
  import dma_adm_pkg::*;
#(
  parameter int LEN_W   = 17,
  parameter int MAX_LEN = 65536
) (
  input  logic               armed,
  input  logic [OP_W-1:0]    op,
  input  logic [STEP_W-1:0]  step,
  input  logic               width_ok,
  input  logic               src_burst,
  input  logic               dst_burst,
  input  logic [LEN_W-1:0]   len,
  input  logic               q_full,
  output adm_status_e        status
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  logic op_bad, step_bad, width_bad, len_bad, word_op;

  always_comb begin
    op_bad    = (op >= OP_LIMIT);
    step_bad  = (step == STEP_FIXALL);
    width_bad = !width_ok
              || (dst_burst && (step == STEP_FIXDST))
              || (src_burst && (step == STEP_FIXSRC));
    word_op   = (op == OP_SWAP) || (op == OP_REVERSE);
    len_bad   = (len == '0) || (len > LEN_MAX) || (word_op && (len[1:0] != 2'b00));
  end

  always_comb begin
    if (!armed)         status = ST_FAIL;
    else if (op_bad)    status = ST_BAD_OP;
    else if (step_bad)  status = ST_BAD_STEP;
    else if (width_bad) status = ST_BAD_WIDTH;
    else if (len_bad)   status = ST_BAD_LEN;
    else if (q_full)    status = ST_FULL;
    else                status = ST_OK;
  end
endmodule

// File: rtl/dma_adm_fifo.sv
module dma_adm_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dma_admit_top.sv
module dma_admit_top
  import dma_adm_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DEPTH   = 16,
  parameter int LEN_W   = 17,
  parameter int MAX_LEN = 65536,
  localparam int CNT_W  = $clog2(DEPTH+1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic               req_valid,
  input  logic [AW-1:0]      req_src,
  input  logic [AW-1:0]      req_dst,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [2:0]         req_op,
  input  logic [1:0]         req_step,
  input  logic [4:0]         req_width,
  output logic               resp_valid,
  output logic [2:0]         resp_status,
  input  logic               deq_ready,
  output logic               q_valid,
  output logic [AW-1:0]      q_src,
  output logic [AW-1:0]      q_dst,
  output logic [LEN_W-1:0]   q_len,
  output logic [2:0]         q_op,
  output logic [1:0]         q_step,
  output logic [4:0]         q_width,
  output logic [CNT_W-1:0]   pend_count
);
  localparam int DW = 2*AW + LEN_W + OP_W + STEP_W + WIDTH_W;

  logic        armed;
  logic        w_ok, s_burst, d_burst;
  logic        q_full, q_empty, push;
  adm_status_e verdict;
  logic [DW-1:0] wdata, rdata;

  always_ff @(posedge clk) begin
    if (rst)      armed <= 1'b0;
    else if (arm) armed <= 1'b1;
  end

  dma_adm_width_dec u_wdec (
    .code      (req_width),
    .code_ok   (w_ok),
    .src_burst (s_burst),
    .dst_burst (d_burst)
  );

  dma_adm_rules #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_rules (
    .armed     (armed),
    .op        (req_op),
    .step      (req_step),
    .width_ok  (w_ok),
    .src_burst (s_burst),
    .dst_burst (d_burst),
    .len       (req_len),
    .q_full    (q_full),
    .status    (verdict)
  );

  assign push  = req_valid && (verdict == ST_OK);
  assign wdata = {req_src, req_dst, req_len, req_op, req_step, req_width};

  dma_adm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (wdata),
    .pop   (deq_ready),
    .rdata (rdata),
    .count (pend_count),
    .full  (q_full),
    .empty (q_empty)
  );

  assign q_valid = !q_empty;
  assign {q_src, q_dst, q_len, q_op, q_step, q_width} = rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_status <= ST_OK;
    end else begin
      resp_valid  <= req_valid;
      resp_status <= req_valid ? verdict : ST_OK;
    end
  end
endmodule

// File: rtl/dma_admit_chk.sv
module dma_admit_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             arm,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [1:0]       req_step,
  input logic             deq_ready,
  input logic             resp_valid,
  input logic [2:0]       resp_status,
  input logic             q_valid,
  input logic [CNT_W-1:0] pend_count
);
  logic seen_arm;
  always_ff @(posedge clk) begin
    if (rst)      seen_arm <= 1'b0;
    else if (arm) seen_arm <= 1'b1;
  end

  a_r1_valid_matches_count: assert property (@(posedge clk) disable iff (rst)
    q_valid == (pend_count != '0));

  a_r2_fail_unarmed: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !seen_arm) |=> (resp_status == 3'd1));

  a_r3_bad_op: assert property (@(posedge clk) disable iff (rst)
    (req_valid && seen_arm && req_op >= 3'd4) |=> (resp_status == 3'd4));

  a_r4_bad_step: assert property (@(posedge clk) disable iff (rst)
    (req_valid && seen_arm && req_op < 3'd4 && req_step == 2'd3) |=> (resp_status == 3'd5));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    pend_count <= CNT_W'(DEPTH));

  a_r9_full_refused: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pend_count == CNT_W'(DEPTH)) |=> (resp_status != 3'd0));

  a_r11_count_step: assert property (@(posedge clk) disable iff (rst)
    int'(pend_count) == int'($past(pend_count))
      + ((resp_valid && resp_status == 3'd0) ? 1 : 0)
      - ($past(deq_ready && q_valid) ? 1 : 0));

  a_r12_resp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);
endmodule

bind dma_admit_top dma_admit_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .arm         (arm),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_step    (req_step),
  .deq_ready   (deq_ready),
  .resp_valid  (resp_valid),
  .resp_status (resp_status),
  .q_valid     (q_valid),
  .pend_count  (pend_count)
);

// File: tb/dma_admit_top_tb_top.sv
`timescale 1ns/1ps
module dma_admit_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_src = '0, req_dst = '0;
  logic [16:0] req_len = '0;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_step = '0;
  logic [4:0]  req_width = '0;
  logic        deq_ready = 1'b0;
  logic        resp_valid, q_valid;
  logic [2:0]  resp_status, q_op;
  logic [31:0] q_src, q_dst;
  logic [16:0] q_len;
  logic [1:0]  q_step;
  logic [4:0]  q_width;
  logic [4:0]  pend_count;

  always #5 clk = ~clk;

  dma_admit_top dut_i (
    .clk(clk), .rst(rst), .arm(arm), .req_valid(req_valid),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
    .req_op(req_op), .req_step(req_step), .req_width(req_width),
    .resp_valid(resp_valid), .resp_status(resp_status),
    .deq_ready(deq_ready), .q_valid(q_valid), .q_src(q_src), .q_dst(q_dst),
    .q_len(q_len), .q_op(q_op), .q_step(q_step), .q_width(q_width),
    .pend_count(pend_count)
  );

  typedef struct {
    logic [31:0] s, d;
    int len, op, step, width;
  } desc_t;

  desc_t mq[$];
  int    checks = 0, errors = 0, seq = 0;
  bit    m_armed = 0, done = 0;

  function automatic int ref_status(bit armed_f, int op, int step, int width, int len, int cnt);
    bit sb, db;
    if (!armed_f) return 1;
    if (op >= 4) return 4;
    if (step == 3) return 5;
    if (width >= 16) return 2;
    sb = (width >= 12 && width <= 15);
    db = (width >= 9 && width <= 11) || width == 15;
    if (db && step == 1) return 2;
    if (sb && step == 2) return 2;
    if (len == 0 || len > 65536) return 3;
    if ((op == 2 || op == 3) && (len % 4) != 0) return 3;
    if (cnt >= 16) return 6;
    return 0;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int op, int stp, int width, int len, bit pop, string tag);
    int    exp_st;
    bit    do_push, do_pop;
    desc_t dsc;
    seq++;
    dsc.s = 32'h1000_0000 + seq; dsc.d = 32'h2000_0000 + seq * 7;
    dsc.len = len; dsc.op = op; dsc.step = stp; dsc.width = width;
    req_valid = v; req_src = dsc.s; req_dst = dsc.d; req_len = 17'(len);
    req_op = 3'(op); req_step = 2'(stp); req_width = 5'(width); deq_ready = pop;
    exp_st  = ref_status(m_armed, op, stp, width, len, mq.size());
    do_push = v && exp_st == 0;
    do_pop  = pop && mq.size() > 0;
    @(posedge clk); #2;
    if (do_pop) void'(mq.pop_front());
    if (do_push) mq.push_back(dsc);
    check(resp_valid == v, tag, "resp_valid", resp_valid, v);
    if (v) check(int'(resp_status) == exp_st, tag, "status", resp_status, exp_st);
    check(int'(pend_count) == mq.size(), tag, "pend_count", pend_count, mq.size());
    check(q_valid == (mq.size() > 0), tag, "q_valid", q_valid, mq.size() > 0);
    if (mq.size() > 0) begin
      check(q_src == mq[0].s && q_dst == mq[0].d, tag, "head addr", q_src, mq[0].s);
      check(int'(q_len) == mq[0].len && int'(q_op) == mq[0].op &&
            int'(q_step) == mq[0].step && int'(q_width) == mq[0].width,
            tag, "head fields", q_len, mq[0].len);
    end
    req_valid = 0; deq_ready = 0;
  endtask

  task automatic pulse_arm();
    arm = 1; @(posedge clk); #2; arm = 0; m_armed = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(resp_valid == 0 && pend_count == 0 && q_valid == 0, "R1", "reset", pend_count, 0);
    rst = 0;
    @(posedge clk); #2;
    check(resp_valid == 0 && pend_count == 0 && q_valid == 0, "R1", "after reset", pend_count, 0);
    // R2: unarmed, also with a bad op (rank)
    step(1, 1, 0, 0, 64, 0, "R2");
    step(1, 6, 3, 20, 0, 0, "R2");
    // R2: submission in same cycle as the first arm pulse still fails
    arm = 1; step(1, 1, 0, 0, 64, 0, "R2"); arm = 0; m_armed = 1;
    // R11: pop on empty has no effect
    step(0, 0, 0, 0, 0, 1, "R11");
    // R10 accepted
    step(1, 1, 0, 0, 64, 0, "R10");
    step(1, 0, 1, 5, 1, 0, "R10");
    // R3
    step(1, 4, 0, 0, 64, 0, "R3");
    step(1, 7, 0, 0, 64, 0, "R3");
    // R4
    step(1, 1, 3, 0, 64, 0, "R4");
    // R5 width rules
    step(1, 1, 0, 16, 64, 0, "R5");
    step(1, 1, 1, 9, 64, 0, "R5");
    step(1, 1, 1, 15, 64, 0, "R5");
    step(1, 1, 2, 12, 64, 0, "R5");
    step(1, 1, 2, 9, 64, 0, "R5");
    step(1, 1, 1, 12, 64, 0, "R5");
    step(1, 1, 0, 15, 64, 0, "R5");
    // R6 length limits
    step(1, 1, 0, 0, 0, 0, "R6");
    step(1, 1, 0, 0, 65537, 0, "R6");
    step(1, 1, 0, 0, 131071, 0, "R6");
    step(1, 1, 0, 0, 65536, 0, "R6");
    // R7 word-multiple ops
    step(1, 2, 0, 0, 6, 0, "R7");
    step(1, 3, 0, 0, 65535, 0, "R7");
    step(1, 2, 0, 0, 8, 0, "R7");
    step(1, 0, 0, 0, 7, 0, "R7");
    // R8 ranking
    step(1, 5, 3, 20, 0, 0, "R8");
    step(1, 1, 3, 20, 0, 0, "R8");
    step(1, 1, 1, 10, 0, 0, "R8");
    // R11 simultaneous push and pop
    step(1, 1, 0, 4, 100, 1, "R11");
    // R9 fill to full
    while (mq.size() < 16) step(1, 1, 0, 8, 4 * mq.size() + 4, 0, "R10");
    step(1, 1, 0, 0, 64, 0, "R9");
    step(1, 5, 0, 0, 64, 0, "R9");
    step(1, 1, 0, 0, 64, 1, "R9");
    step(1, 1, 0, 0, 64, 1, "R11");
    // drain in order
    while (mq.size() > 0) step(0, 0, 0, 0, 0, 1, "R10");
    // R12 idle then mixed traffic
    step(0, 0, 0, 0, 0, 0, "R12");
    for (int i = 0; i < 400; i++) begin
      int lens[6] = '{0, 1, 4, 6, 65536, 65537};
      step(($urandom % 4) != 0, $urandom % 6, $urandom % 4, $urandom % 18,
           lens[$urandom % 6], ($urandom % 3) == 0, "R8");
    end
    // R1 reset mid-traffic
    rst = 1; @(posedge clk); #2; rst = 0; mq.delete(); m_armed = 0;
    check(resp_valid == 0 && pend_count == 0 && q_valid == 0, "R1", "re-reset", pend_count, 0);
    step(1, 1, 0, 0, 64, 0, "R2");
    pulse_arm();
    step(1, 1, 0, 0, 64, 0, "R10");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule